// File: doc/BRIEF.md
# UART Bit-Timing Generator with Selectable Oversampling

This block produces the bit timing of a 16550-style serial port and holds the registers that set it. A 32-bit register port gives software access to a line-control register, a 16-bit divisor latch, an oversampling mode register, a programmable sample count, a programmable sample point and a rate-fix word. Register index N sits at byte address N<<2. The divisor latch is reachable only while bit 7 of the line-control register is set.

Two independent timers run from the same settings. Each timer has a prescaler that divides the clock by the divisor, and a sub-bit counter that counts prescaler steps. The transmit timer gives `tx_tick` in the first clock of every bit. The receive timer gives `rx_bit_start` in the first clock of every bit, and `rx_sample` at the sampling position inside the bit. A pulse on `rx_start` realigns the receive timer to an incoming start edge. A write to any timing register restarts both timers.

The mode register selects the oversampling ratio. The four mode values are:

- X16 (0): ratio 16, sample at sub-bit 8.
- Reserved (1): behaves the same as X16.
- X4 (2): ratio 4, sample at sub-bit 2.
- Programmable (3): ratio is sample count + 1, and the sample position is the sample point register.

Top module: `uart_bitclk_gen`

## Requirements
- R1: After reset, every register reads back its reset value. Line control (byte address 0x0C) reads 0. The mode register (0x24) reads 0. Sample count (0x28) reads 0x00. Sample point (0x2C) reads 0xFF. Rate-fix (0x34) reads 0. The divisor low byte (0x00) and high byte (0x04) read 0 while bit 7 of line control is set.
- R2: The divisor low byte is at 0x00 and the high byte is at 0x04. Both are written and read only while bit 7 of line control is 1. While that bit is 0, writes to 0x00 and 0x04 change nothing and restart nothing, and reads at those addresses return 0. Addresses not listed here read 0.
- R3: With mode bits [1:0] at 0 or 1, the bit period is D×16 clocks, where D is the effective divisor. `tx_tick` and `rx_bit_start` pulse at cycles 0, P, 2P, ... counted from the last restart, where P is the bit period and cycle 0 is the first clock after the restarting edge.
- R4: With mode 2, the bit period is D×4 clocks.
- R5: With mode 3, the bit period is D×(C+1) clocks, where C is the 8-bit sample count. The ratio can therefore reach 256.
- R6: `rx_sample` pulses D×S clocks after each `rx_bit_start`. S is 8 in modes 0 and 1, 2 in mode 2, and the sample point register in mode 3. In mode 3 with a sample point greater than C, `rx_sample` never fires.
- R7: In modes 0, 1 and 2, the sample count and sample point values have no effect on timing.
- R8: A divisor of 0 gives the same timing as a divisor of 1.
- R9: A write to the divisor (with bit 7 of line control set), mode, sample count, sample point or rate-fix register restarts both timers. `tx_tick` and `rx_bit_start` are high in the clock after the write. A write to line control does not restart the timers.
- R10: A pulse on `rx_start` restarts only the receive timer, so `rx_bit_start` is high in the following clock. The transmit timing is unaffected.
- R11: Each output is a one-clock pulse. It is high on consecutive clocks only when the interval between two events is one clock.
- R12: The rate-fix register stores and reads back all 32 bits. Its value has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | UART clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address (index<<2) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| rx_start | input | 1 | Receive start-edge pulse; realigns the receive timer |
| tx_tick | output | 1 | First clock of each transmit bit |
| rx_sample | output | 1 | Receive sampling strobe |
| rx_bit_start | output | 1 | First clock of each receive bit |

## Verification
The assertions check several properties on every cycle:

- The prescaler stays below the effective divisor, and the sub-bit counter stays within the selected ratio.
- The sub-bit counter advances by one only at the end of a prescaler period.
- A timing-register write or a start edge is followed in the next clock by a bit-start pulse.
- A prescaler step stays single-cycle unless the divisor is one.
- A locked divisor write leaves the latch unchanged.

Some behaviours only the bench scenarios can show. These are the full bit periods in each mode and the sample position inside the bit. They also include the absence of a strobe when the sample point lies beyond the count, and the lack of effect of sample settings outside the programmable mode and of the rate-fix value. Those come from the bench's behavioural model, which counts clocks since the last restart and is compared on every clock.

// File: rtl/uart_bt_pkg.sv
package uart_bt_pkg;

    localparam int BT_DIV_W   = 16;
    localparam int BT_SUB_W   = 8;
    localparam int BT_BYTE_W  = 8;

    localparam int IDX_DIV_LO = 0;
    localparam int IDX_DIV_HI = 1;
    localparam int IDX_LCTL   = 3;
    localparam int IDX_MODE   = 9;
    localparam int IDX_SCNT   = 10;
    localparam int IDX_SPNT   = 11;
    localparam int IDX_RFIX   = 13;
    localparam int LATCH_BIT  = 7;

    localparam logic [BT_BYTE_W-1:0] SCNT_RESET = 8'h00;
    localparam logic [BT_BYTE_W-1:0] SPNT_RESET = 8'hFF;

    typedef enum logic [1:0] {
        MODE_X16  = 2'd0,
        MODE_RSVD = 2'd1,
        MODE_X4   = 2'd2,
        MODE_PROG = 2'd3
    } os_mode_e;

    typedef struct packed {
        logic [BT_DIV_W-1:0]  divisor;
        os_mode_e             mode;
        logic [BT_SUB_W-1:0]  samp_cnt;
        logic [BT_SUB_W-1:0]  samp_pnt;
    } timing_cfg_t;

endpackage

// File: rtl/uart_bt_regs.sv
module uart_bt_regs
    import uart_bt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output timing_cfg_t       cfg,
    output logic              cfg_wr
);

    localparam int HALF_W = BT_DIV_W / 2;

    logic [BT_BYTE_W-1:0] lctl_q;
    logic [HALF_W-1:0]    div_lo_q;
    logic [HALF_W-1:0]    div_hi_q;
    os_mode_e             mode_q;
    logic [BT_SUB_W-1:0]  scnt_q;
    logic [BT_SUB_W-1:0]  spnt_q;
    logic [DATA_W-1:0]    rfix_q;

    function automatic logic at_idx(input logic [ADDR_W-1:0] a, input int idx);
        return a == ADDR_W'(idx << 2);
    endfunction

    logic latch_open;
    logic hit_lo, hit_hi, hit_lctl, hit_mode, hit_scnt, hit_spnt, hit_rfix;

    always_comb begin
        latch_open = lctl_q[LATCH_BIT];
        hit_lo     = at_idx(addr, IDX_DIV_LO) && latch_open;
        hit_hi     = at_idx(addr, IDX_DIV_HI) && latch_open;
        hit_lctl   = at_idx(addr, IDX_LCTL);
        hit_mode   = at_idx(addr, IDX_MODE);
        hit_scnt   = at_idx(addr, IDX_SCNT);
        hit_spnt   = at_idx(addr, IDX_SPNT);
        hit_rfix   = at_idx(addr, IDX_RFIX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lctl_q   <= '0;
            div_lo_q <= '0;
            div_hi_q <= '0;
            mode_q   <= MODE_X16;
            scnt_q   <= SCNT_RESET;
            spnt_q   <= SPNT_RESET;
            rfix_q   <= '0;
        end else if (wr_en) begin
            if (hit_lctl) lctl_q   <= wdata[BT_BYTE_W-1:0];
            if (hit_lo)   div_lo_q <= wdata[HALF_W-1:0];
            if (hit_hi)   div_hi_q <= wdata[HALF_W-1:0];
            if (hit_mode) mode_q   <= os_mode_e'(wdata[1:0]);
            if (hit_scnt) scnt_q   <= wdata[BT_SUB_W-1:0];
            if (hit_spnt) spnt_q   <= wdata[BT_SUB_W-1:0];
            if (hit_rfix) rfix_q   <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_lctl)      rdata = DATA_W'(lctl_q);
        else if (hit_lo)   rdata = DATA_W'(div_lo_q);
        else if (hit_hi)   rdata = DATA_W'(div_hi_q);
        else if (hit_mode) rdata = DATA_W'(mode_q);
        else if (hit_scnt) rdata = DATA_W'(scnt_q);
        else if (hit_spnt) rdata = DATA_W'(spnt_q);
        else if (hit_rfix) rdata = rfix_q;
    end

    always_comb begin
        cfg.divisor  = {div_hi_q, div_lo_q};
        cfg.mode     = mode_q;
        cfg.samp_cnt = scnt_q;
        cfg.samp_pnt = spnt_q;
        cfg_wr = wr_en && (hit_lo || hit_hi || hit_mode || hit_scnt || hit_spnt || hit_rfix);
    end

    // R2: a divisor write while the latch bit is clear leaves the divisor unchanged
    a_r2_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && at_idx(addr, IDX_DIV_LO) && !lctl_q[LATCH_BIT]) |=> $stable(div_lo_q));

    // R9: a line-control write alone does not restart the timers
    a_r9_lctl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && at_idx(addr, IDX_LCTL)) |-> !cfg_wr);

endmodule

// File: rtl/uart_bt_ratio.sv
module uart_bt_ratio
    import uart_bt_pkg::*;
(
    input  timing_cfg_t         cfg,
    output logic [BT_DIV_W-1:0] div_m1,
    output logic [BT_SUB_W-1:0] last_sub,
    output logic [BT_SUB_W-1:0] mark_sub
);

    localparam logic [BT_SUB_W-1:0] X16_LAST = BT_SUB_W'(15);
    localparam logic [BT_SUB_W-1:0] X16_MARK = BT_SUB_W'(8);
    localparam logic [BT_SUB_W-1:0] X4_LAST  = BT_SUB_W'(3);
    localparam logic [BT_SUB_W-1:0] X4_MARK  = BT_SUB_W'(2);

    always_comb begin
        div_m1 = (cfg.divisor == '0) ? '0 : cfg.divisor - BT_DIV_W'(1);
    end

    always_comb begin
        unique case (cfg.mode)
            MODE_X16, MODE_RSVD: begin
                last_sub = X16_LAST;
                mark_sub = X16_MARK;
            end
            MODE_X4: begin
                last_sub = X4_LAST;
                mark_sub = X4_MARK;
            end
            MODE_PROG: begin
                last_sub = cfg.samp_cnt;
                mark_sub = cfg.samp_pnt;
            end
        endcase
    end

endmodule

// File: rtl/uart_bt_timer.sv
module uart_bt_timer
    import uart_bt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic [BT_DIV_W-1:0] div_m1,
    input  logic [BT_SUB_W-1:0] last_sub,
    output logic                step,
    output logic [BT_SUB_W-1:0] sub_o
);

    logic [BT_DIV_W-1:0] pre_q;
    logic [BT_SUB_W-1:0] sub_q;
    logic                pre_end;

    always_comb begin
        pre_end = (pre_q >= div_m1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            sub_q <= '0;
        end else if (restart) begin
            pre_q <= '0;
            sub_q <= '0;
        end else if (pre_end) begin
            pre_q <= '0;
            sub_q <= (sub_q >= last_sub) ? '0 : sub_q + BT_SUB_W'(1);
        end else begin
            pre_q <= pre_q + BT_DIV_W'(1);
        end
    end

    always_comb begin
        step  = (pre_q == '0);
        sub_o = sub_q;
    end

    // R8: the prescaler never passes the effective divisor
    a_r8_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= div_m1);

    // R5: the sub-bit counter stays inside the selected ratio
    a_r5_sub_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        sub_q <= last_sub);

    // R5: the sub-bit counter advances by one at the end of each prescaler period
    a_r5_sub_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_q == div_m1 && sub_q != last_sub && !restart) |=> (sub_q == $past(sub_q) + BT_SUB_W'(1)));

    // R9: a restart leaves both counters at zero
    a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pre_q == '0 && sub_q == '0));

    // R11: a step lasts one clock unless the divisor is one
    a_r11_step_single: assert property (@(posedge clk) disable iff (!rst_n)
        (step && div_m1 != '0 && !restart) |=> !step);

endmodule

// File: rtl/uart_bitclk_gen.sv
module uart_bitclk_gen
    import uart_bt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rx_start,
    output logic              tx_tick,
    output logic              rx_sample,
    output logic              rx_bit_start
);

    localparam int N_TIMERS = 2;
    localparam int TX_SIDE  = 0;
    localparam int RX_SIDE  = 1;

    timing_cfg_t         cfg;
    logic                cfg_wr;
    logic [BT_DIV_W-1:0] div_m1;
    logic [BT_SUB_W-1:0] last_sub;
    logic [BT_SUB_W-1:0] mark_sub;

    logic [N_TIMERS-1:0] restart_v;
    logic [N_TIMERS-1:0] step_v;
    logic [BT_SUB_W-1:0] sub_v [N_TIMERS];

    uart_bt_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .cfg    (cfg),
        .cfg_wr (cfg_wr)
    );

    uart_bt_ratio ratio_i (
        .cfg      (cfg),
        .div_m1   (div_m1),
        .last_sub (last_sub),
        .mark_sub (mark_sub)
    );

    for (genvar g = 0; g < N_TIMERS; g++) begin : gen_timer
        assign restart_v[g] = cfg_wr | ((g == RX_SIDE) ? rx_start : 1'b0);

        uart_bt_timer timer_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (restart_v[g]),
            .div_m1   (div_m1),
            .last_sub (last_sub),
            .step     (step_v[g]),
            .sub_o    (sub_v[g])
        );
    end

    always_comb begin
        tx_tick      = step_v[TX_SIDE] && (sub_v[TX_SIDE] == '0);
        rx_bit_start = step_v[RX_SIDE] && (sub_v[RX_SIDE] == '0);
        rx_sample    = step_v[RX_SIDE] && (sub_v[RX_SIDE] == mark_sub);
    end

    // R9: a timing-register write starts a fresh bit on both sides
    a_r9_write_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (tx_tick && rx_bit_start));

    // R10: a start edge realigns the receive side in the next clock
    a_r10_rx_realign: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> rx_bit_start);

    // R6: a sample strobe only occurs when the sample position lies inside the bit
    a_r6_sample_inside: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sample |-> (mark_sub <= last_sub));

endmodule

// File: tb/uart_bitclk_gen_tb.sv
`timescale 1ns/1ps
module uart_bitclk_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_start = 1'b0;
    logic        tx_tick, rx_sample, rx_bit_start;

    always #4 clk = ~clk;

    uart_bitclk_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .rx_start     (rx_start),
        .tx_tick      (tx_tick),
        .rx_sample    (rx_sample),
        .rx_bit_start (rx_bit_start)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    string cur_req = "R3";

    // behavioural model: register shadows and clocks since last restart
    int m_lctl, m_dlo, m_dhi, m_mode, m_cnt, m_pnt;
    int tx_age, rx_age;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit rs;
        int a;
        if (!rst_n) begin
            m_lctl = 0; m_dlo = 0; m_dhi = 0; m_mode = 0; m_cnt = 0; m_pnt = 255;
            tx_age = 0; rx_age = 0;
        end else begin
            rs = 1'b0;
            if (reg_wr) begin
                a = reg_addr;
                if (a == 8'h00 && m_lctl[7]) begin m_dlo = reg_wdata[7:0]; rs = 1'b1; end
                if (a == 8'h04 && m_lctl[7]) begin m_dhi = reg_wdata[7:0]; rs = 1'b1; end
                if (a == 8'h0C) m_lctl = reg_wdata[7:0];
                if (a == 8'h24) begin m_mode = reg_wdata[1:0]; rs = 1'b1; end
                if (a == 8'h28) begin m_cnt = reg_wdata[7:0]; rs = 1'b1; end
                if (a == 8'h2C) begin m_pnt = reg_wdata[7:0]; rs = 1'b1; end
                if (a == 8'h34) rs = 1'b1;
            end
            tx_age = rs ? 0 : tx_age + 1;
            rx_age = (rs || rx_start) ? 0 : rx_age + 1;
        end
    end

    always @(negedge clk) begin
        int d, ratio, sp, per;
        if (rst_n && !done) begin
            d = m_dhi * 256 + m_dlo;
            if (d == 0) d = 1;
            if (m_mode == 3) begin ratio = m_cnt + 1; sp = m_pnt; end
            else if (m_mode == 2) begin ratio = 4; sp = 2; end
            else begin ratio = 16; sp = 8; end
            per = d * ratio;
            check(tx_tick == ((tx_age % per) == 0), cur_req, "tx_tick", tx_tick, (tx_age % per) == 0);
            check(rx_bit_start == ((rx_age % per) == 0), cur_req, "rx_bit_start",
                  rx_bit_start, (rx_age % per) == 0);
            check(rx_sample == (sp < ratio && (rx_age % per) == d * sp), cur_req, "rx_sample",
                  rx_sample, (sp < ratio && (rx_age % per) == d * sp));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); #1;
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, "readback", reg_rdata, exp);
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rx_edge();
        @(negedge clk); #1;
        rx_start = 1'b1;
        @(negedge clk); #1;
        rx_start = 1'b0;
        check(rx_bit_start == 1'b1, "R10", "rx_bit_start after start edge", rx_bit_start, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R1: reset readback
        rd(8'h0C, 32'h0, "R1");
        rd(8'h24, 32'h0, "R1");
        rd(8'h28, 32'h00, "R1");
        rd(8'h2C, 32'hFF, "R1");
        rd(8'h34, 32'h0, "R1");
        rd(8'h00, 32'h0, "R2");
        wr(8'h0C, 32'h83);
        rd(8'h00, 32'h0, "R1");
        rd(8'h04, 32'h0, "R1");
        rd(8'h0C, 32'h83, "R1");

        // R8: divisor 0 behaves as 1, mode 0 gives 16 clocks per bit
        cur_req = "R8";
        run(70);

        // R2 and R9: divisor write through the latch
        cur_req = "R9";
        wr(8'h00, 32'h03);
        check(tx_tick == 1'b1, "R9", "tx_tick after divisor write", tx_tick, 1);
        rd(8'h00, 32'h03, "R2");
        run(30);
        wr(8'h0C, 32'h03);
        cur_req = "R2";
        wr(8'h00, 32'h55);
        rd(8'h00, 32'h0, "R2");
        rd(8'h10, 32'h0, "R2");
        run(100);
        wr(8'h0C, 32'h80);
        rd(8'h00, 32'h03, "R2");
        wr(8'h0C, 32'h00);
        cur_req = "R3";
        run(150);

        // R3: reserved mode behaves as mode 0
        wr(8'h24, 32'h1);
        run(150);

        // R4 and R7: mode 2 ignores the sample settings
        cur_req = "R4";
        wr(8'h24, 32'h2);
        run(60);
        cur_req = "R7";
        wr(8'h28, 32'h05);
        wr(8'h2C, 32'h01);
        run(80);
        wr(8'h24, 32'h0);
        run(120);

        // R5 and R6: programmable ratio, divisor 2
        cur_req = "R5";
        wr(8'h0C, 32'h80);
        wr(8'h00, 32'h02);
        wr(8'h0C, 32'h00);
        wr(8'h28, 32'd9);
        wr(8'h2C, 32'd4);
        wr(8'h24, 32'h3);
        run(100);
        cur_req = "R6";
        wr(8'h2C, 32'd0);
        run(60);
        wr(8'h2C, 32'd9);
        run(60);
        wr(8'h2C, 32'd200);
        run(80);
        wr(8'h2C, 32'd4);

        // R10: start edges realign only the receive side
        cur_req = "R10";
        run(7);
        rx_edge();
        run(13);
        rx_edge();
        run(3);
        rx_edge();
        run(60);

        // R9: mid-bit write restarts both sides
        cur_req = "R9";
        run(5);
        wr(8'h28, 32'd9);
        check(rx_bit_start == 1'b1, "R9", "rx_bit_start after count write", rx_bit_start, 1);
        run(50);

        // R11: one-clock bit with count 0 and divisor 0
        cur_req = "R11";
        wr(8'h0C, 32'h80);
        wr(8'h00, 32'h00);
        wr(8'h0C, 32'h00);
        wr(8'h28, 32'd0);
        wr(8'h2C, 32'd0);
        run(20);
        wr(8'h2C, 32'd1);
        run(20);

        // R5: largest ratio
        cur_req = "R5";
        wr(8'h28, 32'd255);
        wr(8'h2C, 32'd127);
        run(600);

        // R12: rate-fix stores all bits and has no timing effect
        cur_req = "R12";
        wr(8'h34, 32'hDEADBEEF);
        rd(8'h34, 32'hDEADBEEF, "R12");
        run(300);

        // R2 and R3: wide divisor through the high byte
        cur_req = "R3";
        wr(8'h24, 32'h0);
        wr(8'h0C, 32'h80);
        wr(8'h04, 32'h01);
        wr(8'h00, 32'h02);
        rd(8'h04, 32'h01, "R2");
        wr(8'h0C, 32'h00);
        run(9000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule